// File: doc/BRIEF.md
# Memory Bank Configuration Register File and Address Decoder

This block holds the setup state of a four-bank memory controller and decides which bank, if any, a physical address falls in. Software reaches every internal register through an indirect pair of ports. A write to the selector port picks an internal register by its byte offset. The data port then reads or writes the register that is selected. The block stores the controller enable, a status word that records enable transitions, refresh and power-timer settings, an ECC error record, and one configuration word per bank.

Each bank word carries an 8 MiB-aligned base, a three-bit size code and an enable flag. On every cycle a registered decoder compares the lookup address against all enabled banks. It reports a hit and the index of the lowest-numbered matching bank one cycle later. The decoder only reports hits while the controller enable bit is set. An interrupt line stays high for as long as the ECC error record holds a nonzero value.

Top module: `memctl_bank_top`

## Requirements
- R1: After reset, the selector reads 0, the control word reads 0x00800000, refresh reads 0x05F00000, the power timer reads 0x07C00000, and every other stored register reads 0.
- R2: A write with acc_port=0 loads the selector. acc_port=0 returns the selector on acc_rdata. acc_port=1 returns the selected register. acc_rdata is registered and shows the selection one clock after acc_port is presented.
- R3: Write masks are applied as follows. Control word: 0xFFE00000 at offset 0x20. Refresh: 0x3FF80000 at 0x30. ECC config: 0x00F00000 at 0x94. Bank words: 0xFFDEE001 at 0x40+4*i. A power-timer write at 0x34 stores (data & 0xF8000000) | 0x07C00000. The error address at 0x10 stores all 32 bits.
- R4: The status word at 0x24 ignores writes. Offset 0x80 (timing) reads 0xFFFFFFFF. Any offset with no register behind it reads 0xFFFFFFFF.
- R5: The two error-status registers at 0x00 and 0x08 are write-one-to-clear. Writing all ones to them leaves them reading 0.
- R6: When control bit 31 goes from 0 to 1, status bit 31 clears. When it goes from 1 to 0, status bit 31 sets. Otherwise status bit 31 holds.
- R7: Status bit 30 takes the new value of control bit 30 whenever a control write changes that bit, and holds otherwise.
- R8: A write to offset 0x98 stores data & 0xFFF0F000. ecc_irq is high exactly while that register is nonzero.
- R9: A bank word holds the base in bits 31:23, a size code in bits 19:17 and an enable flag in bit 0. The bank size is 4 MiB << code. An enabled bank with an aligned base hits for base <= address < base + size.
- R10: A bank with size code 7 never hits.
- R11: When several banks match, lookup_bank is the lowest index among them.
- R12: lookup_hit and lookup_bank reflect lookup_addr and the configuration one clock edge later, and they hold until then.
- R13: No bank hits while control bit 31 is 0 or while the bank's own enable bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_wr | input | 1 | Write strobe for the port picked by acc_port |
| acc_port | input | 1 | 0 = selector port, 1 = data port |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Registered read data of the port picked by acc_port |
| lookup_addr | input | 32 | Physical address to decode |
| lookup_hit | output | 1 | Registered: the address falls in an enabled bank |
| lookup_bank | output | 2 | Registered index of the winning bank |
| ecc_irq | output | 1 | High while the ECC error record is nonzero |

## Verification
The bench builds the block with its default of four banks. Each bank is programmed in isolation with every one of the eight size codes at an aligned base. Probe addresses are placed just below each window, at its first byte, at its middle, at its last byte, and just past its end. The expected result is derived from base and size arithmetic alone. With four banks, every index can be placed alone, and the overlap cases can be built with three and then four banks stacked on one window. The register side covers every mapped offset, two unmapped ones, and the full sequence of control-bit transitions that drives the status bits.

// File: rtl/memctl_pkg.sv
package memctl_pkg;
  localparam int WORD_W = 32;

  localparam logic [31:0] OFS_ERR0    = 32'h00;
  localparam logic [31:0] OFS_ERR1    = 32'h08;
  localparam logic [31:0] OFS_ERRADDR = 32'h10;
  localparam logic [31:0] OFS_CTRL    = 32'h20;
  localparam logic [31:0] OFS_STAT    = 32'h24;
  localparam logic [31:0] OFS_REFR    = 32'h30;
  localparam logic [31:0] OFS_PWRT    = 32'h34;
  localparam logic [31:0] OFS_BANK0   = 32'h40;
  localparam logic [31:0] OFS_TIMING  = 32'h80;
  localparam logic [31:0] OFS_ECCCFG  = 32'h94;
  localparam logic [31:0] OFS_ECCERR  = 32'h98;

  localparam logic [31:0] MSK_CTRL   = 32'hFFE0_0000;
  localparam logic [31:0] MSK_REFR   = 32'h3FF8_0000;
  localparam logic [31:0] MSK_ECCCFG = 32'h00F0_0000;
  localparam logic [31:0] MSK_ECCERR = 32'hFFF0_F000;
  localparam logic [31:0] MSK_BANK   = 32'hFFDE_E001;
  localparam logic [31:0] MSK_PWRT   = 32'hF800_0000;
  localparam logic [31:0] FIX_PWRT   = 32'h07C0_0000;

  localparam logic [31:0] RST_CTRL = 32'h0080_0000;
  localparam logic [31:0] RST_REFR = 32'h05F0_0000;
  localparam logic [31:0] RST_PWRT = 32'h07C0_0000;

  localparam logic [2:0] SIZE_BAD = 3'd7;

  // Mask over address bits 31:22 (4 MiB blocks) for a given size code.
  function automatic logic [9:0] blk_mask(input logic [2:0] code);
    return 10'h3FF << code;
  endfunction
endpackage

// File: rtl/memctl_cfg_regs.sv
module memctl_cfg_regs
  import memctl_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              acc_wr,
  input  logic                              acc_port,
  input  logic [WORD_W-1:0]                 acc_wdata,
  output logic [WORD_W-1:0]                 acc_rdata,
  output logic [NUM_BANKS-1:0][WORD_W-1:0]  bank_word,
  output logic                              ctrl_en,
  output logic                              ecc_irq
);
  logic [WORD_W-1:0] sel_q;
  logic [WORD_W-1:0] err0_q, err1_q, erraddr_q, ctrl_q, stat_q;
  logic [WORD_W-1:0] refr_q, pwrt_q, ecccfg_q, eccerr_q;
  logic [NUM_BANKS-1:0][WORD_W-1:0] bank_q;
  logic [WORD_W-1:0] rd_mux;
  logic              data_wr;
  logic [WORD_W-1:0] ctrl_new;

  assign data_wr  = acc_wr && acc_port;
  assign ctrl_new = acc_wdata & MSK_CTRL;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
    end else if (acc_wr && !acc_port) begin
      sel_q <= acc_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err0_q    <= '0;
      err1_q    <= '0;
      erraddr_q <= '0;
      refr_q    <= RST_REFR;
      pwrt_q    <= RST_PWRT;
      ecccfg_q  <= '0;
      eccerr_q  <= '0;
    end else if (data_wr) begin
      case (sel_q)
        OFS_ERR0:    err0_q    <= err0_q & ~acc_wdata;
        OFS_ERR1:    err1_q    <= err1_q & ~acc_wdata;
        OFS_ERRADDR: erraddr_q <= acc_wdata;
        OFS_REFR:    refr_q    <= acc_wdata & MSK_REFR;
        OFS_PWRT:    pwrt_q    <= (acc_wdata & MSK_PWRT) | FIX_PWRT;
        OFS_ECCCFG:  ecccfg_q  <= acc_wdata & MSK_ECCCFG;
        OFS_ECCERR:  eccerr_q  <= acc_wdata & MSK_ECCERR;
        default: ;
      endcase
    end
  end

  // Control word and the status bits it drives.
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= RST_CTRL;
      stat_q <= '0;
    end else if (data_wr && sel_q == OFS_CTRL) begin
      ctrl_q <= ctrl_new;
      if (!ctrl_q[31] && ctrl_new[31]) begin
        stat_q[31] <= 1'b0;
      end else if (ctrl_q[31] && !ctrl_new[31]) begin
        stat_q[31] <= 1'b1;
      end
      if (ctrl_q[30] != ctrl_new[30]) begin
        stat_q[30] <= ctrl_new[30];
      end
    end
  end

  for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
    localparam logic [WORD_W-1:0] BANK_OFS = OFS_BANK0 + WORD_W'(4 * gi);
    always_ff @(posedge clk) begin
      if (rst) begin
        bank_q[gi] <= '0;
      end else if (data_wr && sel_q == BANK_OFS) begin
        bank_q[gi] <= acc_wdata & MSK_BANK;
      end
    end
  end

  always_comb begin
    rd_mux = '1;
    case (sel_q)
      OFS_ERR0:    rd_mux = err0_q;
      OFS_ERR1:    rd_mux = err1_q;
      OFS_ERRADDR: rd_mux = erraddr_q;
      OFS_CTRL:    rd_mux = ctrl_q;
      OFS_STAT:    rd_mux = stat_q;
      OFS_REFR:    rd_mux = refr_q;
      OFS_PWRT:    rd_mux = pwrt_q;
      OFS_TIMING:  rd_mux = '1;
      OFS_ECCCFG:  rd_mux = ecccfg_q;
      OFS_ECCERR:  rd_mux = eccerr_q;
      default:     rd_mux = '1;
    endcase
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (sel_q == OFS_BANK0 + WORD_W'(4 * i)) rd_mux = bank_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_rdata <= '0;
    end else begin
      acc_rdata <= acc_port ? rd_mux : sel_q;
    end
  end

  assign bank_word = bank_q;
  assign ctrl_en   = ctrl_q[31];
  assign ecc_irq   = |eccerr_q;
endmodule

// File: rtl/memctl_bank_match.sv
module memctl_bank_match
  import memctl_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              ctrl_en,
  input  logic [NUM_BANKS-1:0][WORD_W-1:0]  bank_word,
  input  logic [WORD_W-1:0]                 lookup_addr,
  output logic                              lookup_hit,
  output logic [IDX_W-1:0]                  lookup_bank
);
  logic [NUM_BANKS-1:0] match;
  logic [9:0]           blk;
  logic                 hit_n;
  logic [IDX_W-1:0]     idx_n;

  assign blk = lookup_addr[31:22];

  for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_cmp
    logic [2:0] code;
    logic [9:0] base_blk;
    logic [9:0] msk;
    assign code     = bank_word[gi][19:17];
    assign base_blk = {bank_word[gi][31:23], 1'b0};
    assign msk      = blk_mask(code);
    assign match[gi] = ctrl_en && bank_word[gi][0] && (code != SIZE_BAD)
                       && (((blk ^ base_blk) & msk) == 10'd0);
  end

  // Lowest index wins: scan downward so the last assignment is the lowest.
  always_comb begin
    hit_n = 1'b0;
    idx_n = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_n = 1'b1;
        idx_n = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lookup_hit  <= 1'b0;
      lookup_bank <= '0;
    end else begin
      lookup_hit  <= hit_n;
      lookup_bank <= idx_n;
    end
  end
endmodule

// File: rtl/memctl_bank_top.sv
module memctl_bank_top
  import memctl_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_wr,
  input  logic              acc_port,
  input  logic [31:0]       acc_wdata,
  output logic [31:0]       acc_rdata,
  input  logic [31:0]       lookup_addr,
  output logic              lookup_hit,
  output logic [IDX_W-1:0]  lookup_bank,
  output logic              ecc_irq
);
  logic [NUM_BANKS-1:0][WORD_W-1:0] bank_word;
  logic                             ctrl_en;

  memctl_cfg_regs #(.NUM_BANKS(NUM_BANKS)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .acc_wr    (acc_wr),
    .acc_port  (acc_port),
    .acc_wdata (acc_wdata),
    .acc_rdata (acc_rdata),
    .bank_word (bank_word),
    .ctrl_en   (ctrl_en),
    .ecc_irq   (ecc_irq)
  );

  memctl_bank_match #(.NUM_BANKS(NUM_BANKS)) u_match (
    .clk         (clk),
    .rst         (rst),
    .ctrl_en     (ctrl_en),
    .bank_word   (bank_word),
    .lookup_addr (lookup_addr),
    .lookup_hit  (lookup_hit),
    .lookup_bank (lookup_bank)
  );
endmodule

// File: rtl/memctl_bank_checker.sv
module memctl_bank_checker
  import memctl_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input logic                             clk,
  input logic                             rst,
  input logic                             acc_wr,
  input logic                             acc_port,
  input logic [31:0]                      acc_wdata,
  input logic [31:0]                      lookup_addr,
  input logic                             lookup_hit,
  input logic [IDX_W-1:0]                 lookup_bank,
  input logic                             ecc_irq,
  input logic                             ctrl_en,
  input logic [NUM_BANKS-1:0][WORD_W-1:0] bank_word
);
  logic [31:0] sel_seen;
  logic        ecc_wr;

  always_ff @(posedge clk) begin
    if (rst) sel_seen <= '0;
    else if (acc_wr && !acc_port) sel_seen <= acc_wdata;
  end

  assign ecc_wr = acc_wr && acc_port && (sel_seen == OFS_ECCERR);

  // R8: a nonzero masked ECC error write raises the line
  a_r8_irq_raise: assert property (@(posedge clk) disable iff (rst)
    (ecc_wr && ((acc_wdata & MSK_ECCERR) != 32'd0)) |=> ecc_irq);

  // R8: a masked-zero ECC error write drops the line
  a_r8_irq_drop: assert property (@(posedge clk) disable iff (rst)
    (ecc_wr && ((acc_wdata & MSK_ECCERR) == 32'd0)) |=> !ecc_irq);

  // R13: a hit needs the controller enabled in the cycle before
  a_r13_gate: assert property (@(posedge clk) disable iff (rst)
    lookup_hit |-> $past(ctrl_en));

  // R12: unchanged inputs over two cycles give unchanged outputs
  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    (lookup_addr == $past(lookup_addr) && bank_word == $past(bank_word)
     && ctrl_en == $past(ctrl_en))
    |=> ($stable(lookup_hit) && $stable(lookup_bank)));
endmodule

bind memctl_bank_top memctl_bank_checker #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .acc_wr      (acc_wr),
  .acc_port    (acc_port),
  .acc_wdata   (acc_wdata),
  .lookup_addr (lookup_addr),
  .lookup_hit  (lookup_hit),
  .lookup_bank (lookup_bank),
  .ecc_irq     (ecc_irq),
  .ctrl_en     (ctrl_en),
  .bank_word   (bank_word)
);

// File: tb/memctl_bank_top_bench.sv
`timescale 1ns/1ps
module memctl_bank_top_bench;
  localparam int NB = 4;
  localparam longint unsigned MIB = 64'd1 << 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_wr = 1'b0;
  logic        acc_port = 1'b0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic [31:0] lookup_addr = '0;
  logic        lookup_hit;
  logic [1:0]  lookup_bank;
  logic        ecc_irq;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [31:0] mdl_bank [NB];
  bit          mdl_ctrl = 1'b0;

  always #2 clk = ~clk;

  memctl_bank_top u_memctl_bank_top (
    .clk(clk), .rst(rst), .acc_wr(acc_wr), .acc_port(acc_port),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .lookup_addr(lookup_addr),
    .lookup_hit(lookup_hit), .lookup_bank(lookup_bank), .ecc_irq(ecc_irq)
  );

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not complete");
      summary();
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr_port(bit port, logic [31:0] data);
    @(negedge clk);
    acc_port = port; acc_wdata = data; acc_wr = 1'b1;
    @(negedge clk);
    acc_wr = 1'b0;
  endtask

  task automatic wr_reg(logic [31:0] ofs, logic [31:0] data);
    wr_port(1'b0, ofs);
    wr_port(1'b1, data);
  endtask

  task automatic rd_reg(logic [31:0] ofs, output logic [31:0] val);
    wr_port(1'b0, ofs);
    acc_port = 1'b1;
    @(negedge clk);
    val = acc_rdata;
  endtask

  task automatic set_bank(int b, logic [31:0] w);
    wr_reg(32'h40 + 32'(4 * b), w);
    mdl_bank[b] = w & 32'hFFDEE001;
  endtask

  task automatic set_ctrl(logic [31:0] w);
    wr_reg(32'h20, w);
    mdl_ctrl = w[31];
  endtask

  // Expected decode from base/size ranges (R9, R10, R11, R13).
  task automatic expect_dec(longint unsigned a, output bit h, output int idx);
    h = 1'b0; idx = 0;
    for (int i = NB - 1; i >= 0; i--) begin
      longint unsigned base, size;
      int code;
      code = int'(mdl_bank[i][19:17]);
      base = longint'(mdl_bank[i][31:23]) << 23;
      size = (4 * MIB) << code;
      if (mdl_ctrl && mdl_bank[i][0] && code != 7 && a >= base && a < base + size) begin
        h = 1'b1; idx = i;
      end
    end
  endtask

  task automatic probe(string req, longint unsigned a);
    bit h; int idx;
    if (a >= (64'd1 << 32)) return;
    expect_dec(a, h, idx);
    @(negedge clk);
    lookup_addr = a[31:0];
    @(negedge clk);
    chk({req, " hit"}, {31'd0, lookup_hit}, {31'd0, h});
    if (h) chk({req, " bank"}, {30'd0, lookup_bank}, 32'(idx));
  endtask

  initial begin
    logic [31:0] v;
    for (int i = 0; i < NB; i++) mdl_bank[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    chk("R1 rdata", acc_rdata, 32'h0);
    chk("R1 hit", {31'd0, lookup_hit}, 32'd0);
    chk("R1 irq", {31'd0, ecc_irq}, 32'd0);
    acc_port = 1'b0; @(negedge clk);
    chk("R1 selector", acc_rdata, 32'h0);
    rd_reg(32'h20, v); chk("R1 ctrl", v, 32'h00800000);
    rd_reg(32'h30, v); chk("R1 refresh", v, 32'h05F00000);
    rd_reg(32'h34, v); chk("R1 pwrt", v, 32'h07C00000);
    rd_reg(32'h24, v); chk("R1 status", v, 32'h0);
    rd_reg(32'h98, v); chk("R1 eccerr", v, 32'h0);
    for (int i = 0; i < NB; i++) begin
      rd_reg(32'h40 + 32'(4 * i), v); chk("R1 bank", v, 32'h0);
    end

    // R2 selector readback, one-cycle registered read
    wr_port(1'b0, 32'h0000_0055);
    acc_port = 1'b0; @(negedge clk);
    chk("R2 selector readback", acc_rdata, 32'h55);
    wr_reg(32'h10, 32'h1234_5678);
    acc_port = 1'b1; @(negedge clk);
    chk("R2 data port", acc_rdata, 32'h1234_5678);

    // R3 masks
    wr_reg(32'h30, 32'hFFFFFFFF); rd_reg(32'h30, v); chk("R3 refresh", v, 32'h3FF80000);
    wr_reg(32'h94, 32'hFFFFFFFF); rd_reg(32'h94, v); chk("R3 ecccfg", v, 32'h00F00000);
    wr_reg(32'h34, 32'hFFFFFFFF); rd_reg(32'h34, v); chk("R3 pwrt ones", v, 32'hFFC00000);
    wr_reg(32'h34, 32'h0);        rd_reg(32'h34, v); chk("R3 pwrt zero", v, 32'h07C00000);
    set_bank(3, 32'hFFFFFFFF);    rd_reg(32'h4C, v); chk("R3 bank", v, 32'hFFDEE001);

    // R4 read-only status, all-ones reads
    rd_reg(32'h80, v); chk("R4 timing", v, 32'hFFFFFFFF);
    rd_reg(32'h0C, v); chk("R4 unmapped 0C", v, 32'hFFFFFFFF);
    rd_reg(32'h100, v); chk("R4 unmapped 100", v, 32'hFFFFFFFF);

    // R5 W1C error status
    wr_reg(32'h00, 32'hFFFFFFFF); rd_reg(32'h00, v); chk("R5 err0", v, 32'h0);
    wr_reg(32'h08, 32'hFFFFFFFF); rd_reg(32'h08, v); chk("R5 err1", v, 32'h0);

    // R6 / R7 status transitions
    set_ctrl(32'h80000000); rd_reg(32'h24, v); chk("R6 enable", v, 32'h00000000);
    set_ctrl(32'h00000000); rd_reg(32'h24, v); chk("R6 disable", v, 32'h80000000);
    set_ctrl(32'hC0000000); rd_reg(32'h24, v); chk("R7 set30 R6 clear31", v, 32'h40000000);
    set_ctrl(32'h40000000); rd_reg(32'h24, v); chk("R6 set31 R7 hold30", v, 32'hC0000000);
    set_ctrl(32'h00000000); rd_reg(32'h24, v); chk("R7 clear30", v, 32'h80000000);
    wr_reg(32'h24, 32'hFFFFFFFF); rd_reg(32'h24, v); chk("R4 status ignores write", v, 32'h80000000);
    set_ctrl(32'hFFFFFFFF); rd_reg(32'h20, v); chk("R3 ctrl", v, 32'hFFE00000);
    rd_reg(32'h24, v); chk("R6 R7 both", v, 32'h40000000);

    // R8 ECC interrupt
    wr_reg(32'h98, 32'h000F0FFF);
    chk("R8 masked zero irq", {31'd0, ecc_irq}, 32'd0);
    rd_reg(32'h98, v); chk("R8 masked zero", v, 32'h0);
    wr_reg(32'h98, 32'h00100000);
    chk("R8 irq high", {31'd0, ecc_irq}, 32'd1);
    rd_reg(32'h98, v); chk("R8 value", v, 32'h00100000);
    wr_reg(32'h98, 32'h0);
    chk("R8 irq low", {31'd0, ecc_irq}, 32'd0);

    // R10 code 7 never matches (bank 3 holds 0xFFDEE001)
    probe("R10 code7", 64'hFF80_0000);
    probe("R10 code7 hi", 64'hFFFF_FFFF);
    set_bank(3, 32'h0);

    // R9 sweep: each bank, each size code, window edges
    for (int b = 0; b < NB; b++) begin
      for (int code = 0; code < 8; code++) begin
        longint unsigned size, step, base;
        size = (4 * MIB) << code;
        step = (size > 8 * MIB) ? size : 8 * MIB;
        base = (step * 3) % (64'd1 << 32);
        set_bank(b, base[31:0] | (32'(code) << 17) | 32'd1);
        probe("R9 below", base - 4 * MIB);
        probe("R9 first", base);
        probe("R9 middle", base + size / 2);
        probe("R9 last", base + size - 1);
        probe("R9 past", base + size);
        set_bank(b, 32'h0);
      end
    end

    // R11 overlap priority
    set_bank(1, 32'h0100_0000 | (32'd3 << 17) | 32'd1);
    set_bank(2, 32'h0100_0000 | (32'd2 << 17) | 32'd1);
    set_bank(3, 32'h0000_0000 | (32'd4 << 17) | 32'd1);
    probe("R11 three", 64'h0100_0000);
    set_bank(0, 32'h0100_0000 | (32'd0 << 17) | 32'd1);
    probe("R11 four", 64'h0100_0000);
    probe("R11 outside b0", 64'h0180_0000);

    // R12 one-cycle latency
    @(negedge clk);
    lookup_addr = 32'h4000_0000;
    @(negedge clk);
    chk("R12 miss settles", {31'd0, lookup_hit}, 32'd0);
    lookup_addr = 32'h0100_0000;
    #1;
    chk("R12 holds before edge", {31'd0, lookup_hit}, 32'd0);
    @(negedge clk);
    chk("R12 updates after edge", {31'd0, lookup_hit}, 32'd1);

    // R13 gating
    set_ctrl(32'h0);
    probe("R13 ctrl off", 64'h0100_0000);
    set_ctrl(32'h80000000);
    set_bank(0, 32'h0100_0000);
    set_bank(1, 32'h0100_0000 | (32'd3 << 17));
    set_bank(2, 32'h0);
    set_bank(3, 32'h0);
    probe("R13 bank enable off", 64'h0100_0000);

    summary();
  end
endmodule